// File: doc/BRIEF.md
# Oversampling Sample Accumulator

This block sits between an analog-to-digital converter's result stream and the register that holds the final conversion value. When oversampling is switched on, it requests a power-of-two number of conversions of one channel, adds the 12-bit samples into a wide running sum, shifts the sum right by a programmable amount and emits one 16-bit result with a single-cycle valid strobe. When oversampling is switched off, every trigger requests one conversion and each returned sample is forwarded unchanged.

Two request policies are available. In burst mode a single trigger starts the whole series of conversions, which run back to back. In stepped mode every individual conversion waits for a trigger of its own, and the result appears once the last sample of the series has arrived. The converter is expected to answer each request with exactly one sample-valid pulse some cycles later. A trigger that arrives while a conversion is still outstanding, or while a burst is running, is dropped.

Top module: `ovs_sum_unit`

## Requirements
- R1: After reset, conv_req_o and res_vld_o are low and res_data_o is zero.
- R2: With ovs_en_i low, each trigger issues one conv_req_o pulse, and each returned sample is presented on res_data_o zero-extended to 16 bits with one res_vld_o pulse per sample.
- R3: With ovs_en_i high, ratio code c (0 to 7) makes one result out of exactly 2^(c+1) samples: 2, 4, 8, 16, 32, 64, 128 or 256.
- R4: Shift code s right-shifts the sum by s bits for s from 0 to 8; codes 9 to 15 act as a shift of 8.
- R5: The sum is held at 20 bits, so 256 samples of 4095 cannot overflow; the output is the low 16 bits of the shifted sum (256 × 4095 with no shift gives 0xFF00).
- R6: In burst mode (trig_step_i low) one trigger produces all 2^(c+1) conversion requests with no further trigger.
- R7: In stepped mode (trig_step_i high) each conversion request needs its own trigger; the result appears only after the final sample of the series.
- R8: A trigger arriving while a conversion is outstanding or a burst is running is ignored, including one that lands in the cycle the final sample of a burst is taken.
- R9: Clearing ovs_en_i mid-series discards the partial sum and resets the sample count; a sample taken while it is low is passed through, and the next enabled series starts from zero.
- R10: A sample-valid pulse with no conversion outstanding is ignored: it neither produces a result nor enters the sum.
- R11: res_vld_o is a single-cycle pulse; it is never high in two consecutive cycles.
- R12: conv_req_o is a single-cycle pulse and at most one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Conversion trigger |
| smp_vld_i | input | 1 | Converter sample valid |
| smp_data_i | input | 12 | Converter sample value |
| ovs_en_i | input | 1 | Oversampling enable; low forwards samples directly |
| ratio_code_i | input | 3 | Ratio code, 2^(code+1) samples per result |
| shift_code_i | input | 4 | Right shift applied to the sum, clamped to 8 |
| trig_step_i | input | 1 | 1: each conversion needs a trigger; 0: one trigger per series |
| conv_req_o | output | 1 | Conversion request pulse toward the converter |
| res_vld_o | output | 1 | Result valid pulse |
| res_data_o | output | 16 | Result value |

## Verification
The collision of interest is a trigger landing in the very cycle the final sample of a burst is accepted, when the accumulator closes the series and the request logic could restart it. The bench's converter model raises the trigger on the same clock as it presents that last sample, so the two are exactly coincident. It is judged correct when exactly one result with the expected sum appears, the request count equals the ratio with no extra request, and a later trigger starts a new series whose sum begins from zero. A second coincidence, the enable dropping in the same cycle a mid-series sample arrives, is provoked the same way and must yield that raw sample as a pass-through result with no further requests.

// File: rtl/ovs_sum_pkg.sv
package ovs_sum_pkg;

   // how the block handles a trigger and an incoming sample
   typedef enum logic [1:0] {
      MODE_PASS  = 2'd0,   // oversampling off, one sample per trigger
      MODE_BURST = 2'd1,   // one trigger runs the whole series
      MODE_STEP  = 2'd2    // every conversion needs a trigger
   } ovs_mode_e;

   // largest log2 ratio reachable with a ratio code of the given width
   function automatic int max_ratio_log(input int code_w);
      return 1 << code_w;
   endfunction

   // number of shifter stages for a shift range 0..max_sh
   function automatic int shift_stages(input int max_sh);
      return (max_sh < 1) ? 1 : $clog2(max_sh + 1);
   endfunction

endpackage

// File: rtl/ovs_rshift.sv
module ovs_rshift #(
   parameter int IN_W      = 20,
   parameter int OUT_W     = 16,
   parameter int CODE_W    = 4,
   parameter int MAX_SHIFT = 8
) (
   input  logic [IN_W-1:0]   din,
   input  logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0]  dout
);
   localparam int STG = ovs_sum_pkg::shift_stages(MAX_SHIFT);

   if (CODE_W < STG) begin : g_bad_code
      $error("ovs_rshift: shift code too narrow for MAX_SHIFT");
   end
   if (OUT_W > IN_W) begin : g_bad_out
      $error("ovs_rshift: output wider than input");
   end

   logic [STG-1:0]  amt;
   logic [IN_W-1:0] stage [0:STG];

   // codes beyond the supported range saturate at the largest shift
   always_comb begin
      if (int'(code) > MAX_SHIFT) amt = STG'(MAX_SHIFT);
      else                        amt = STG'(code);
   end

   assign stage[0] = din;

   for (genvar g = 0; g < STG; g++) begin : g_stage
      assign stage[g+1] = amt[g] ? (stage[g] >> (1 << g)) : stage[g];
   end

   always_comb dout = OUT_W'(stage[STG]);

endmodule

// File: rtl/ovs_req_ctrl.sv
module ovs_req_ctrl
   import ovs_sum_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig_i,
   input  logic      smp_vld_i,
   input  ovs_mode_e mode_i,
   input  logic      series_open_i,
   output logic      conv_req_o,
   output logic      busy_o
);
   logic busy_q;
   logic start;

   // a new conversion starts only when none is outstanding; in burst
   // mode an open series restarts itself without a trigger
   always_comb begin
      start = !busy_q && (trig_i || (mode_i == MODE_BURST && series_open_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         conv_req_o <= 1'b0;
      end else begin
         conv_req_o <= start;
         if (start)          busy_q <= 1'b1;
         else if (smp_vld_i) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;

   // R12: request is a single pulse
   a_r12_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |=> !conv_req_o);

   // R8: no new request while one is outstanding
   a_r8_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !smp_vld_i) |=> !conv_req_o);

endmodule

// File: rtl/ovs_acc_path.sv
module ovs_acc_path
   import ovs_sum_pkg::*;
#(
   parameter int SMP_W        = 12,
   parameter int ACC_W        = 20,
   parameter int RES_W        = 16,
   parameter int RATIO_CODE_W = 3,
   parameter int SHIFT_CODE_W = 4,
   parameter int MAX_SHIFT    = 8,
   parameter int CNT_W        = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take_i,
   input  ovs_mode_e               mode_i,
   input  logic [RATIO_CODE_W-1:0] ratio_code_i,
   input  logic [SHIFT_CODE_W-1:0] shift_code_i,
   input  logic [SMP_W-1:0]        smp_i,
   output logic                    res_vld_o,
   output logic [RES_W-1:0]        res_o,
   output logic                    open_o
);
   logic [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ACC_W-1:0] sum;
   logic [CNT_W:0]   ratio_n;
   logic [CNT_W-1:0] last_idx;
   logic [RES_W-1:0] scaled;

   always_comb begin
      ratio_n  = (CNT_W+1)'(1) << (int'(ratio_code_i) + 1);
      last_idx = CNT_W'(ratio_n - 1'b1);
      sum      = acc_q + ACC_W'(smp_i);
   end

   ovs_rshift #(
      .IN_W      (ACC_W),
      .OUT_W     (RES_W),
      .CODE_W    (SHIFT_CODE_W),
      .MAX_SHIFT (MAX_SHIFT)
   ) u_shift (
      .din  (sum),
      .code (shift_code_i),
      .dout (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         res_vld_o <= 1'b0;
         res_o     <= '0;
      end else begin
         res_vld_o <= 1'b0;
         if (mode_i == MODE_PASS) begin
            acc_q <= '0;
            cnt_q <= '0;
            if (take_i) begin
               res_vld_o <= 1'b1;
               res_o     <= RES_W'(smp_i);
            end
         end else if (take_i) begin
            if (cnt_q >= last_idx) begin
               res_vld_o <= 1'b1;
               res_o     <= scaled;
               acc_q     <= '0;
               cnt_q     <= '0;
            end else begin
               acc_q <= sum;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign open_o = (cnt_q != '0);

   // R9: disabling clears the partial series
   a_r9_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_PASS) |=> (cnt_q == '0 && acc_q == '0));

   // R3: a result in oversampling mode closes the series
   a_r3_series_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_o && $past(mode_i) != MODE_PASS) |-> (cnt_q == '0 && !open_o));

endmodule

// File: rtl/ovs_sum_unit.sv
module ovs_sum_unit
   import ovs_sum_pkg::*;
#(
   parameter int SMP_W        = 12,
   parameter int RES_W        = 16,
   parameter int RATIO_CODE_W = 3,
   parameter int SHIFT_CODE_W = 4,
   parameter int MAX_SHIFT    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trig_i,
   input  logic                    smp_vld_i,
   input  logic [SMP_W-1:0]        smp_data_i,
   input  logic                    ovs_en_i,
   input  logic [RATIO_CODE_W-1:0] ratio_code_i,
   input  logic [SHIFT_CODE_W-1:0] shift_code_i,
   input  logic                    trig_step_i,
   output logic                    conv_req_o,
   output logic                    res_vld_o,
   output logic [RES_W-1:0]        res_data_o
);
   localparam int MAX_LOG = max_ratio_log(RATIO_CODE_W);
   localparam int ACC_W   = SMP_W + MAX_LOG;
   localparam int CNT_W   = MAX_LOG;

   if (RES_W < SMP_W) begin : g_bad_res
      $error("ovs_sum_unit: result narrower than sample");
   end
   if (ACC_W < RES_W) begin : g_bad_acc
      $error("ovs_sum_unit: accumulator narrower than result");
   end
   if (SHIFT_CODE_W < shift_stages(MAX_SHIFT)) begin : g_bad_shift
      $error("ovs_sum_unit: shift code cannot reach MAX_SHIFT");
   end

   ovs_mode_e mode;
   logic      busy;
   logic      take;
   logic      series_open;

   always_comb begin
      if (!ovs_en_i)        mode = MODE_PASS;
      else if (trig_step_i) mode = MODE_STEP;
      else                  mode = MODE_BURST;
   end

   // only a sample answering an outstanding request is accepted
   assign take = smp_vld_i && busy;

   ovs_req_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .trig_i        (trig_i),
      .smp_vld_i     (smp_vld_i),
      .mode_i        (mode),
      .series_open_i (series_open),
      .conv_req_o    (conv_req_o),
      .busy_o        (busy)
   );

   ovs_acc_path #(
      .SMP_W        (SMP_W),
      .ACC_W        (ACC_W),
      .RES_W        (RES_W),
      .RATIO_CODE_W (RATIO_CODE_W),
      .SHIFT_CODE_W (SHIFT_CODE_W),
      .MAX_SHIFT    (MAX_SHIFT),
      .CNT_W        (CNT_W)
   ) u_path (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .mode_i       (mode),
      .ratio_code_i (ratio_code_i),
      .shift_code_i (shift_code_i),
      .smp_i        (smp_data_i),
      .res_vld_o    (res_vld_o),
      .res_o        (res_data_o),
      .open_o       (series_open)
   );

   // R11: result strobe lasts one cycle
   a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o |=> !res_vld_o);

   // R10: a result follows only a sample taken while a request was open
   a_r10_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o |-> ($past(busy) && $past(smp_vld_i)));

   // R2: pass-through forwards the sample unchanged
   a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_o && $past(mode) == MODE_PASS) |-> res_data_o == RES_W'($past(smp_data_i)));

endmodule

// File: tb/ovs_sum_unit_bench.sv
module ovs_sum_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_q = 1'b0;
   logic        coll_trig = 1'b0;
   logic        trig;
   logic        cvt_vld = 1'b0;
   logic [11:0] cvt_data = '0;
   logic        stray_vld = 1'b0;
   logic [11:0] stray_data = '0;
   logic        smp_vld;
   logic [11:0] smp_data;
   logic        en_q = 1'b0;
   logic        hook_drop = 1'b0;
   logic        ovs_en;
   logic [2:0]  rcode = '0;
   logic [3:0]  scode = '0;
   logic        tstep = 1'b0;
   logic        conv_req;
   logic        res_vld;
   logic [15:0] res_data;

   int checks = 0;
   int errors = 0;
   int req_cnt = 0;
   int strobe_pairs = 0;
   logic [15:0] resq[$];

   int gen_base = 0;
   int gen_step = 0;
   int gen_k = 0;
   int trig_on_k = -1;
   int drop_on_k = -1;

   assign trig     = trig_q | coll_trig;
   assign smp_vld  = cvt_vld | stray_vld;
   assign smp_data = stray_vld ? stray_data : cvt_data;
   assign ovs_en   = en_q & ~hook_drop;

   always #2 clk = ~clk;

   ovs_sum_unit u_ovs_sum_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_i       (trig),
      .smp_vld_i    (smp_vld),
      .smp_data_i   (smp_data),
      .ovs_en_i     (ovs_en),
      .ratio_code_i (rcode),
      .shift_code_i (scode),
      .trig_step_i  (tstep),
      .conv_req_o   (conv_req),
      .res_vld_o    (res_vld),
      .res_data_o   (res_data)
   );

   // output monitor
   logic prev_vld = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         if (res_vld) resq.push_back(res_data);
         if (conv_req) req_cnt++;
         if (res_vld && prev_vld) strobe_pairs++;
         prev_vld = res_vld;
      end
   end

   // converter model: answers each request two cycles later
   initial begin
      forever begin
         @(negedge clk);
         if (conv_req) begin
            @(negedge clk);
            @(negedge clk);
            cvt_vld  = 1'b1;
            cvt_data = 12'((gen_base + gen_k * gen_step) & 'hFFF);
            if (gen_k == trig_on_k) coll_trig = 1'b1;
            if (gen_k == drop_on_k) hook_drop = 1'b1;
            gen_k++;
            @(negedge clk);
            cvt_vld   = 1'b0;
            coll_trig = 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic longint exp_res(input int base, input int step, input int k0,
                                      input int n, input int sh);
      longint s = 0;
      for (int i = 0; i < n; i++) s += (base + (k0 + i) * step) & 'hFFF;
      if (sh > 8) sh = 8;
      return (s >> sh) & 'hFFFF;
   endfunction

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_trig();
      @(negedge clk);
      trig_q = 1'b1;
      @(negedge clk);
      trig_q = 1'b0;
   endtask

   task automatic setup(input bit en, input bit step, input int code, input int sh,
                        input int base, input int stp);
      @(negedge clk);
      en_q = en; tstep = step; rcode = 3'(code); scode = 4'(sh);
      gen_base = base; gen_step = stp; gen_k = 0;
      trig_on_k = -1; drop_on_k = -1; hook_drop = 1'b0;
      cycles(2);
      resq.delete();
      req_cnt = 0;
   endtask

   task automatic t_reset();
      chk("R1 conv_req after reset", conv_req, 0);
      chk("R1 res_vld after reset", res_vld, 0);
      chk("R1 res_data after reset", res_data, 0);
   endtask

   task automatic t_pass();
      setup(0, 0, 7, 8, 4093, 1);
      for (int i = 0; i < 3; i++) begin
         pulse_trig();
         cycles(8);
      end
      chk("R2 pass request count", req_cnt, 3);
      chk("R2 pass result count", resq.size(), 3);
      for (int i = 0; i < 3 && i < resq.size(); i++)
         chk("R2 pass value", resq[i], (4093 + i) & 'hFFF);
   endtask

   task automatic burst(input string tag, input int code, input int sh,
                        input int base, input int stp);
      int n = 2 << code;
      setup(1, 0, code, sh, base, stp);
      pulse_trig();
      cycles(4 * n + 20);
      chk({tag, " R6 requests per trigger"}, req_cnt, n);
      chk({tag, " R3 one result"}, resq.size(), 1);
      if (resq.size() > 0)
         chk({tag, " value"}, resq[0], exp_res(base, stp, 0, n, sh));
   endtask

   task automatic t_step();
      setup(1, 1, 1, 1, 50, 9);
      pulse_trig();
      cycles(12);
      chk("R7 one request per trigger", req_cnt, 1);
      chk("R7 no early result", resq.size(), 0);
      for (int i = 0; i < 3; i++) begin
         pulse_trig();
         cycles(12);
      end
      chk("R7 total requests", req_cnt, 4);
      chk("R7 one result", resq.size(), 1);
      if (resq.size() > 0) chk("R7 value", resq[0], exp_res(50, 9, 0, 4, 1));
   endtask

   task automatic t_collide();
      setup(1, 0, 2, 0, 300, 11);
      trig_on_k = 7;
      pulse_trig();
      cycles(60);
      chk("R8 no extra request on final-sample trigger", req_cnt, 8);
      chk("R8 single result", resq.size(), 1);
      if (resq.size() > 0) chk("R8 value", resq[0], exp_res(300, 11, 0, 8, 0));
      trig_on_k = 3;
      resq.delete();
      req_cnt = 0;
      pulse_trig();
      cycles(60);
      chk("R8 mid-burst trigger ignored", req_cnt, 8);
      if (resq.size() > 0) chk("R8 fresh series value", resq[0], exp_res(300, 11, 8, 8, 0));
      else chk("R8 fresh series result", resq.size(), 1);
   endtask

   task automatic t_drop();
      setup(1, 0, 3, 0, 1000, 5);
      drop_on_k = 5;
      pulse_trig();
      cycles(80);
      chk("R9 requests stop after disable", req_cnt, 6);
      chk("R9 pass-through result count", resq.size(), 1);
      if (resq.size() > 0) chk("R9 raw sample forwarded", resq[0], 1000 + 5 * 5);
      @(negedge clk);
      hook_drop = 1'b0;
      drop_on_k = -1;
      gen_k = 0;
      cycles(2);
      resq.delete();
      req_cnt = 0;
      pulse_trig();
      cycles(4 * 16 + 20);
      chk("R9 fresh series count", resq.size(), 1);
      if (resq.size() > 0) chk("R9 fresh series value", resq[0], exp_res(1000, 5, 0, 16, 0));
   endtask

   task automatic t_stray();
      setup(1, 1, 0, 0, 200, 1);
      @(negedge clk);
      stray_vld = 1'b1; stray_data = 12'd4000;
      @(negedge clk);
      stray_vld = 1'b0;
      cycles(4);
      chk("R10 idle stray gives no result", resq.size(), 0);
      chk("R10 idle stray gives no request", req_cnt, 0);
      pulse_trig();
      cycles(10);
      @(negedge clk);
      stray_vld = 1'b1; stray_data = 12'd4000;
      @(negedge clk);
      stray_vld = 1'b0;
      cycles(4);
      chk("R10 stray cannot close series", resq.size(), 0);
      pulse_trig();
      cycles(10);
      chk("R10 result count", resq.size(), 1);
      if (resq.size() > 0) chk("R10 stray excluded from sum", resq[0], exp_res(200, 1, 0, 2, 0));
   endtask

   bit done = 1'b0;

   initial begin
      cycles(3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_pass();
      burst("R3 ratio2", 0, 0, 100, 7);
      burst("R3 ratio16 R4 shift4", 3, 4, 17, 333);
      burst("R3 ratio256 R4 shift8", 7, 8, 4095, 0);
      burst("R4 shift0", 2, 0, 900, 123);
      burst("R4 shift3", 2, 3, 900, 123);
      burst("R4 shift15 clamp", 2, 15, 900, 123);
      burst("R5 truncate 256", 7, 0, 4095, 0);
      burst("R5 truncate 32", 4, 0, 4095, 0);
      t_step();
      t_collide();
      t_drop();
      t_stray();
      chk("R11 no back-to-back strobe", strobe_pairs, 0);
      chk("R12 no request left pending", conv_req, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule